// File: doc/BRIEF.md
# Miss-Correlated Instruction Prefetch Engine

The engine watches the instruction fetch stream and the instruction cache miss events. It learns which earlier fetch should act as the trigger for each miss. A delay line holds the line addresses fetched over the last `MISS_LAT` cycles. When a miss arrives, the slot that entered the delay line exactly `MISS_LAT` cycles earlier names the trigger. Misses to consecutive lines are merged into one run, and each run occupies a single entry of a small direct-mapped history table.

When a trigger line is fetched again, the engine replays its run and issues one prefetch per cycle in ascending line order to the next memory level. Before a line is issued, it passes a filter. The filter drops the line if it matches a recently issued prefetch. It also drops the line when the cache, probed through its existing fetch-port lookup, reports that the line is already present. As a result the cache never needs a second lookup port. Dropped lines are skipped without a stall. The output waits on a ready signal, and a fresh trigger hit abandons any run still in progress.

Top module: `miss_trig_prefetch`

## Requirements
- R1: The trigger for a miss sampled at clock edge n is the line whose fetch was sampled at edge n-MISS_LAT (default 12). A fetch one cycle earlier or later gains no table entry.
- R2: A valid fetch sampled at edge n whose line matches a stored trigger raises `pf_valid` after edge n+2, carrying the run's first line.
- R3: A miss whose line equals the previous miss line plus one extends the open run. Any other miss starts a new run keyed by its own trigger.
- R4: A run holds at most MAX_RUN (default 4) lines. A miss that cannot extend the open run and finds no valid delay-line slot records nothing and closes the open run.
- R5: The history table has TBL_ENTRIES (default 16) entries. The index is the low log2(TBL_ENTRIES) bits of the trigger line, and the full trigger line is compared on lookup. A new run overwrites its slot, so the earlier trigger no longer replays.
- R6: The lines of a run are offered one per cycle in ascending order. `probe_valid`/`probe_line` show the current candidate.
- R7: A candidate that equals any of the last RECENT (default 8) issued prefetches is dropped.
- R8: A candidate is dropped when `probe_hit` is high in the cycle it is shown on `probe_line`. The remaining lines of the run are still issued.
- R9: While `pf_valid` is high and `pf_ready` is low, `pf_valid` and `pf_line` hold. The run resumes in order once `pf_ready` rises.
- R10: A trigger hit while a run is still being issued discards that run's remaining lines and starts the new run. A prefetch already held on the output is kept.
- R11: After synchronous reset, `pf_valid` and `probe_valid` are low and no trigger replays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A fetch is presented this cycle |
| fetch_line | input | LINE_W | Line address of the fetch |
| miss_valid | input | 1 | Instruction cache miss this cycle |
| miss_line | input | LINE_W | Line address that missed |
| probe_valid | output | 1 | A prefetch candidate is being probed |
| probe_line | output | LINE_W | Candidate line shown to the cache fetch-port lookup |
| probe_hit | input | 1 | Cache reports that the probed line is present, same cycle |
| pf_valid | output | 1 | Prefetch request valid |
| pf_line | output | LINE_W | Line address to prefetch |
| pf_ready | input | 1 | Next level accepts the request |

## Verification
The hardest situation to reach is an abort that lands while the output is stalled. The sequence needs a first prefetch held on the output, a second candidate waiting behind it, and a second trigger arriving before anything drains. The stimulus produces this by holding `pf_ready` low across both trigger fetches. It then releases `pf_ready` and confirms that only the held line and the new run come out. Exact trigger pairing is reached by fetching distinct lines in the cycles just before and after the intended trigger, and by placing two misses in back-to-back cycles so that their triggers differ by one slot.

// File: rtl/mtp_pkg.sv
package mtp_pkg;
  localparam int DEF_LINE_W   = 26;
  localparam int DEF_MISS_LAT = 12;
  localparam int DEF_ENTRIES  = 16;
  localparam int DEF_MAX_RUN  = 4;
  localparam int DEF_RECENT   = 8;
endpackage

// File: rtl/mtp_delay_line.sv
module mtp_delay_line #(
  parameter int W     = 26,
  parameter int DEPTH = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_v,
  input  logic [W-1:0] in_line,
  output logic         out_v,
  output logic [W-1:0] out_line
);
  logic [W-1:0] line_q [DEPTH];
  logic [DEPTH-1:0] v_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        line_q[g] <= in_line;
        if (rst) v_q[g] <= 1'b0;
        else     v_q[g] <= in_v;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        line_q[g] <= line_q[g-1];
        if (rst) v_q[g] <= 1'b0;
        else     v_q[g] <= v_q[g-1];
      end
    end
  end

  assign out_v    = v_q[DEPTH-1];
  assign out_line = line_q[DEPTH-1];
endmodule

// File: rtl/mtp_hist_table.sv
module mtp_hist_table #(
  parameter int W       = 26,
  parameter int ENTRIES = 16,
  parameter int LEN_W   = 3,
  parameter int MAX_RUN = 4,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_tag,
  input  logic [W-1:0]     wr_start,
  input  logic [LEN_W-1:0] wr_len,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_v,
  output logic [W-1:0]     rd_tag,
  output logic [W-1:0]     rd_start,
  output logic [LEN_W-1:0] rd_len
);
  localparam logic [LEN_W-1:0] MAXL = LEN_W'(MAX_RUN);

  logic [W-1:0]     tag_mem   [ENTRIES];
  logic [W-1:0]     start_mem [ENTRIES];
  logic [LEN_W-1:0] len_mem   [ENTRIES];
  logic [ENTRIES-1:0] vld_q;

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]   <= wr_tag;
      start_mem[wr_idx] <= wr_start;
      len_mem[wr_idx]   <= wr_len;
    end
    rd_tag   <= tag_mem[rd_idx];
    rd_start <= start_mem[rd_idx];
    rd_len   <= len_mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      rd_v  <= 1'b0;
    end else begin
      if (wr_en) vld_q[wr_idx] <= 1'b1;
      rd_v <= rd_en && vld_q[rd_idx];
    end
  end

  p_len_range_r4: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_len != '0) && (wr_len <= MAXL));
endmodule

// File: rtl/mtp_recent_filter.sv
module mtp_recent_filter #(
  parameter int W     = 26,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_line,
  input  logic [W-1:0] q_line,
  output logic         hit
);
  logic [W-1:0] ln_q [DEPTH];
  logic [DEPTH-1:0] v_q;
  logic [DEPTH-1:0] match;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) v_q[g] <= 1'b0;
      else if (push) v_q[g] <= (g == 0) ? 1'b1 : v_q[(g == 0) ? 0 : g-1];
      if (push) ln_q[g] <= (g == 0) ? push_line : ln_q[(g == 0) ? 0 : g-1];
    end
    assign match[g] = v_q[g] && (ln_q[g] == q_line);
  end

  assign hit = |match;

  // a line already held in the list must never be pushed again
  p_push_unique_r7: assert property (@(posedge clk) disable iff (rst)
    push && (push_line == q_line) |-> !hit);
endmodule

// File: rtl/miss_trig_prefetch.sv
module miss_trig_prefetch #(
  parameter int LINE_W      = mtp_pkg::DEF_LINE_W,
  parameter int MISS_LAT    = mtp_pkg::DEF_MISS_LAT,
  parameter int TBL_ENTRIES = mtp_pkg::DEF_ENTRIES,
  parameter int MAX_RUN     = mtp_pkg::DEF_MAX_RUN,
  parameter int RECENT      = mtp_pkg::DEF_RECENT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_valid,
  input  logic [LINE_W-1:0] fetch_line,
  input  logic              miss_valid,
  input  logic [LINE_W-1:0] miss_line,
  output logic              probe_valid,
  output logic [LINE_W-1:0] probe_line,
  input  logic              probe_hit,
  output logic              pf_valid,
  output logic [LINE_W-1:0] pf_line,
  input  logic              pf_ready
);
  localparam int IDX_W = $clog2(TBL_ENTRIES);
  localparam int LEN_W = $clog2(MAX_RUN + 1);
  localparam logic [LEN_W-1:0] MAXL = LEN_W'(MAX_RUN);
  localparam logic [LEN_W-1:0] ONE  = LEN_W'(1);

  // trigger delay line
  logic              trig_v;
  logic [LINE_W-1:0] trig_line;

  mtp_delay_line #(.W(LINE_W), .DEPTH(MISS_LAT)) u_delay (
    .clk(clk), .rst(rst), .in_v(fetch_valid), .in_line(fetch_line),
    .out_v(trig_v), .out_line(trig_line)
  );

  // run tracking
  logic              run_open;
  logic [LINE_W-1:0] run_tag, run_start, run_last;
  logic [LEN_W-1:0]  run_len;
  logic              extend, fresh, wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [LINE_W-1:0] wr_tag, wr_start;
  logic [LEN_W-1:0]  wr_len;

  always_comb begin
    extend   = miss_valid && run_open &&
               (miss_line == run_last + LINE_W'(1)) && (run_len < MAXL);
    fresh    = miss_valid && !extend && trig_v;
    wr_en    = extend || fresh;
    wr_tag   = extend ? run_tag   : trig_line;
    wr_start = extend ? run_start : miss_line;
    wr_len   = extend ? run_len + ONE : ONE;
    wr_idx   = wr_tag[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_open <= 1'b0;
    end else if (miss_valid) begin
      run_open <= wr_en;
    end
    if (wr_en) begin
      run_tag   <= wr_tag;
      run_start <= wr_start;
      run_last  <= miss_line;
      run_len   <= wr_len;
    end
  end

  // history table and lookup
  logic              rd_v;
  logic [LINE_W-1:0] rd_tag, rd_start;
  logic [LEN_W-1:0]  rd_len;
  logic [LINE_W-1:0] fetch_q;
  logic              hit;

  mtp_hist_table #(.W(LINE_W), .ENTRIES(TBL_ENTRIES), .LEN_W(LEN_W),
                   .MAX_RUN(MAX_RUN)) u_table (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_start(wr_start),
    .wr_len(wr_len),
    .rd_en(fetch_valid), .rd_idx(fetch_line[IDX_W-1:0]),
    .rd_v(rd_v), .rd_tag(rd_tag), .rd_start(rd_start), .rd_len(rd_len)
  );

  always_ff @(posedge clk) fetch_q <= fetch_line;

  assign hit = rd_v && (rd_tag == fetch_q);

  // issue sequencer with filter
  logic              iss_active;
  logic [LINE_W-1:0] iss_line;
  logic [LEN_W-1:0]  iss_left;
  logic              recent_hit, drop, slot_free, send, adv;

  mtp_recent_filter #(.W(LINE_W), .DEPTH(RECENT)) u_recent (
    .clk(clk), .rst(rst), .push(send), .push_line(iss_line),
    .q_line(iss_line), .hit(recent_hit)
  );

  always_comb begin
    drop      = iss_active && (probe_hit || recent_hit);
    slot_free = !pf_valid || pf_ready;
    send      = iss_active && !drop && slot_free;
    adv       = drop || send;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_active <= 1'b0;
    end else if (hit) begin
      iss_active <= 1'b1;
    end else if (adv && (iss_left == ONE)) begin
      iss_active <= 1'b0;
    end
    if (hit) begin
      iss_line <= rd_start;
      iss_left <= rd_len;
    end else if (adv) begin
      iss_line <= iss_line + LINE_W'(1);
      iss_left <= iss_left - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pf_valid <= 1'b0;
    end else if (send) begin
      pf_valid <= 1'b1;
    end else if (pf_ready) begin
      pf_valid <= 1'b0;
    end
    if (send) pf_line <= iss_line;
  end

  assign probe_valid = iss_active;
  assign probe_line  = iss_line;

  p_hold_stall_r9: assert property (@(posedge clk) disable iff (rst)
    pf_valid && !pf_ready |=> pf_valid && $stable(pf_line));

  p_probe_drop_r8: assert property (@(posedge clk) disable iff (rst)
    probe_valid && probe_hit && (!pf_valid || pf_ready) |=> !pf_valid);

  p_ascend_step_r6: assert property (@(posedge clk) disable iff (rst)
    probe_valid && !hit && (!pf_valid || pf_ready) |=>
      !probe_valid || (probe_line == $past(probe_line) + LINE_W'(1)));
endmodule

// File: tb/miss_trig_prefetch_tb_top.sv
module miss_trig_prefetch_tb_top;
  localparam int LW = 26;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fetch_valid = 1'b0;
  logic [LW-1:0] fetch_line = '0;
  logic          miss_valid = 1'b0;
  logic [LW-1:0] miss_line = '0;
  logic          probe_valid;
  logic [LW-1:0] probe_line;
  logic          probe_hit;
  logic          pf_valid;
  logic [LW-1:0] pf_line;
  logic          pf_ready = 1'b1;
  logic          res_en = 1'b0;

  int total = 0;
  int bad = 0;
  logic [LW-1:0] cap [16];
  int cap_n = 0;

  always #4 clk = ~clk;

  miss_trig_prefetch dut_i (
    .clk(clk), .rst(rst),
    .fetch_valid(fetch_valid), .fetch_line(fetch_line),
    .miss_valid(miss_valid), .miss_line(miss_line),
    .probe_valid(probe_valid), .probe_line(probe_line), .probe_hit(probe_hit),
    .pf_valid(pf_valid), .pf_line(pf_line), .pf_ready(pf_ready)
  );

  // bench model of cache contents: lines 0x501 and 0x503 are resident
  always_comb probe_hit = res_en && probe_valid &&
                          ((probe_line == 26'h501) || (probe_line == 26'h503));

  // record every accepted prefetch
  always @(negedge clk) begin
    if (pf_valid && pf_ready && cap_n < 16) begin
      cap[cap_n] = pf_line;
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input bit fv, input logic [LW-1:0] fl,
                       input bit mv, input logic [LW-1:0] ml);
    @(posedge clk); #2;
    fetch_valid = fv; fetch_line = fl; miss_valid = mv; miss_line = ml;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, '0, 0, '0);
  endtask

  task automatic train(input logic [LW-1:0] trig, input logic [LW-1:0] base,
                       input int n);
    drive(1, trig, 0, '0);
    idle(11);
    for (int i = 0; i < n; i++) drive(0, '0, 1, base + LW'(i));
    idle(2);
  endtask

  task automatic replay(input logic [LW-1:0] trig);
    cap_n = 0;
    drive(1, trig, 0, '0);
    idle(14);
  endtask

  task automatic expect_caps(input string req, input int n,
                             input logic [LW-1:0] e0, input logic [LW-1:0] e1,
                             input logic [LW-1:0] e2, input logic [LW-1:0] e3);
    logic [LW-1:0] e [4];
    e[0] = e0; e[1] = e1; e[2] = e2; e[3] = e3;
    chk(cap_n == n, {req, " count"}, 32'(cap_n), 32'(n));
    for (int i = 0; i < n && i < cap_n; i++)
      chk(cap[i] == e[i], {req, " line"}, 32'(cap[i]), 32'(e[i]));
  endtask

  task automatic t_reset_r11;
    @(negedge clk);
    chk(pf_valid == 1'b0, "R11 pf_valid", 32'(pf_valid), 0);
    chk(probe_valid == 1'b0, "R11 probe_valid", 32'(probe_valid), 0);
    replay(26'h101);
    expect_caps("R11 empty table", 0, '0, '0, '0, '0);
  endtask

  // R1 exact pairing, R2 latency, R6 ascending order
  task automatic t_basic_r1_r2;
    drive(1, 26'h10E, 0, '0);
    drive(1, 26'h101, 0, '0);
    drive(1, 26'h10F, 0, '0);
    idle(10);
    for (int i = 0; i < 3; i++) drive(0, '0, 1, 26'h200 + LW'(i));
    idle(2);
    replay(26'h10E);
    expect_caps("R1 earlier fetch", 0, '0, '0, '0, '0);
    replay(26'h10F);
    expect_caps("R1 later fetch", 0, '0, '0, '0, '0);
    cap_n = 0;
    drive(1, 26'h101, 0, '0);
    idle(1);
    @(negedge clk);
    chk(pf_valid == 1'b0, "R2 latency edge n", 32'(pf_valid), 0);
    @(negedge clk);
    chk(pf_valid == 1'b0, "R2 latency edge n+1", 32'(pf_valid), 0);
    @(negedge clk);
    chk(pf_valid == 1'b1, "R2 latency edge n+2", 32'(pf_valid), 1);
    chk(pf_line == 26'h200, "R2 first line", 32'(pf_line), 32'h200);
    idle(10);
    expect_caps("R6 ascending run", 3, 26'h200, 26'h201, 26'h202, '0);
  endtask

  task automatic t_recent_r7;
    replay(26'h101);
    expect_caps("R7 recent drops all", 0, '0, '0, '0, '0);
  endtask

  task automatic t_maxlen_r4;
    train(26'h102, 26'h300, 5);
    replay(26'h102);
    expect_caps("R4 run capped", 4, 26'h300, 26'h301, 26'h302, 26'h303);
  endtask

  task automatic t_split_r3;
    drive(1, 26'h103, 0, '0);
    drive(1, 26'h104, 0, '0);
    idle(10);
    drive(0, '0, 1, 26'h400);
    drive(0, '0, 1, 26'h402);
    idle(2);
    replay(26'h103);
    expect_caps("R3 first run", 1, 26'h400, '0, '0, '0);
    replay(26'h104);
    expect_caps("R3 second run", 1, 26'h402, '0, '0, '0);
  endtask

  task automatic t_probe_r8;
    train(26'h105, 26'h500, 4);
    res_en = 1'b1;
    replay(26'h105);
    res_en = 1'b0;
    expect_caps("R8 probe filter", 2, 26'h500, 26'h502, '0, '0);
  endtask

  task automatic t_stall_r9;
    train(26'h106, 26'h600, 3);
    pf_ready = 1'b0;
    cap_n = 0;
    drive(1, 26'h106, 0, '0);
    idle(6);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(pf_valid == 1'b1, "R9 hold valid", 32'(pf_valid), 1);
      chk(pf_line == 26'h600, "R9 hold line", 32'(pf_line), 32'h600);
    end
    drive(0, '0, 0, '0);
    pf_ready = 1'b1;
    idle(8);
    expect_caps("R9 resume order", 3, 26'h600, 26'h601, 26'h602, '0);
  endtask

  task automatic t_abort_r10;
    train(26'h107, 26'h700, 4);
    train(26'h108, 26'h800, 2);
    pf_ready = 1'b0;
    cap_n = 0;
    drive(1, 26'h107, 0, '0);
    idle(3);
    drive(1, 26'h108, 0, '0);
    idle(4);
    pf_ready = 1'b1;
    idle(10);
    expect_caps("R10 abort", 3, 26'h700, 26'h800, 26'h801, '0);
  endtask

  task automatic t_replace_r5;
    train(26'h109, 26'h900, 1);
    train(26'h119, 26'hA00, 1);
    replay(26'h109);
    expect_caps("R5 evicted trigger", 0, '0, '0, '0, '0);
    replay(26'h119);
    expect_caps("R5 new occupant", 1, 26'hA00, '0, '0, '0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;
    t_reset_r11();
    t_basic_r1_r2();
    t_recent_r7();
    t_maxlen_r4();
    t_split_r3();
    t_probe_r8();
    t_stall_r9();
    t_abort_r10();
    t_replace_r5();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule